// File: doc/BRIEF.md
# Prescaled Auto-Reload Interval Timer

This block produces a periodic interrupt for a microcontroller peripheral. A divide-by-16 prescaler runs on a timer-clock enable input, and each prescaled tick increments a 16-bit counter. The counter starts from a value that software chooses. When a tick arrives while the counter holds all ones, the block sets an overflow flag, raises its level interrupt and reloads the counter on the next cycle, so the events repeat every 16 × (65536 − reload) enabled timer cycles.

Software reaches the block through a small word-wide write and read port with three registers: a run control bit, the reload value and the overflow status. A write to the reload register also places that value straight into the counter. Software cannot write the counter in any other way and cannot read it. The interrupt is cleared by writing 1 to the status bit.

The counter is run by a three-state machine. STOP holds the counter. RUN advances it on every prescaled tick. WRAP lasts one cycle and reloads it. The transitions are:
- STOP→RUN when the run bit is 1.
- RUN→WRAP on a tick while the count is 0xFFFF. This is the overflow event.
- RUN→STOP when the run bit is cleared.
- WRAP→RUN if the run bit is still 1.
- WRAP→STOP otherwise.

Top module: `ivt_top`

## Requirements
- R1: After reset the run bit, the reload value, the counter and the overflow flag are all zero, and `irq` is low.
- R2: Writing 1 to the run register (address 0, bit 0) starts counting. The prescaler starts from zero, so the first counter increment falls on the 16th enabled cycle after the write edge. The first overflow comes 16 × (65536 − reload) cycles after that edge.
- R3: Writing the reload register (address 1, bits 15:0) stores the value and loads the counter at the same edge. This holds even while the counter is running.
- R4: Writing 0 to the run register freezes the counter at its current value and clears the prescaler. A later write of 1 resumes counting from the frozen value with a full 16-cycle first tick.
- R5: A prescaled tick that arrives while the counter is 0xFFFF sets the overflow flag and drives `irq` high at that edge.
- R6: On the cycle after an overflow the counter is reloaded from the reload register, so overflows repeat every 16 × (65536 − reload) cycles.
- R7: The prescaler advances only on cycles where `tick_en` is 1. With `tick_en` high on every second cycle, the overflow period doubles.
- R8: Writing a word with bit 0 set to the status register (address 2) clears the flag and lowers `irq`. Writing a word with bit 0 clear has no effect.
- R9: If an overflow event and a clearing status write fall on the same edge, the flag stays at 1.
- R10: Reads return the following, with all unused bits zero:
  - address 0: the run bit in bit 0;
  - address 1: the reload value;
  - address 2: the flag in bit 0;
  - address 3: zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer clock enable; the prescaler counts only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Combinational read data |
| irq | output | 1 | Level interrupt, equal to the overflow flag |

## Verification
The bench sweeps sixteen reload values next to the top of the range and measures the exact cycle of the first overflow and of the next one.

Each error shows up as a timing difference:
- A prescaler that keeps its phase across a stop would overflow early after a resume.
- A reload that skips the counter would overflow a whole period late.
- An off-by-one at 0xFFFF would shift every period by 16 cycles.
- Counting while `tick_en` is low would leave the gated period at the ungated value.

The bench also places a clearing write on the same edge as an overflow. A design in which the clear wins would drop that interrupt.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Register addresses; the bench and software rely on these values.
    localparam int REG_RUN    = 0;
    localparam int REG_RELOAD = 1;
    localparam int REG_STATUS = 2;

    // Counter sequencing states.
    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_WRAP = 2'd2
    } ctr_state_t;

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              flag,
    output logic [DATA_W-1:0] rd_data,
    output logic              run_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              reload_wr,
    output logic              status_clr
);

    localparam logic [ADDR_W-1:0] A_RUN    = ADDR_W'(REG_RUN);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(REG_RELOAD);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);

    logic run_wr;

    // Write decode
    assign run_wr     = wr_en && (wr_addr == A_RUN);
    assign reload_wr  = wr_en && (wr_addr == A_RELOAD);
    assign status_clr = wr_en && (wr_addr == A_STATUS) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (run_wr) begin
            run_q <= wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (reload_wr) begin
            reload_q <= wr_data[CNT_W-1:0];
        end
    end

    // Read mux: unused bits and addresses return zero
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_RUN:    rd_data = DATA_W'(run_q);
            A_RELOAD: rd_data = DATA_W'(reload_q);
            A_STATUS: rd_data = DATA_W'(flag);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick_en,
    output logic tick
);

    localparam logic [PRE_W-1:0] PRE_LAST = '1;
    localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);

    logic [PRE_W-1:0] pre_q;

    // Cleared while stopped so every start sees a full division period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
        end else if (tick_en) begin
            pre_q <= pre_q + PRE_ONE;
        end
    end

    assign tick = run && tick_en && (pre_q == PRE_LAST);

endmodule

// File: rtl/ivt_ctr_fsm.sv
module ivt_ctr_fsm
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ctr_state_t st_q, st_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_STOP;
        end else begin
            st_q <= st_nx;
        end
    end

    // Next state and overflow event
    always_comb begin
        st_nx   = st_q;
        ovf_evt = 1'b0;
        unique case (st_q)
            ST_STOP: begin
                if (run) begin
                    st_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (tick && (cnt == CNT_TOP)) begin
                    ovf_evt = 1'b1;
                    st_nx   = ST_WRAP;
                end else if (!run) begin
                    st_nx = ST_STOP;
                end
            end
            ST_WRAP: begin
                st_nx = run ? ST_RUN : ST_STOP;
            end
            default: st_nx = ST_STOP;
        endcase
    end

    // Counter: software load beats the wrap reload, which beats counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (reload_wr) begin
            cnt <= reload_wdata;
        end else if (st_q == ST_WRAP) begin
            cnt <= reload_q;
        end else if ((st_q == ST_RUN) && tick && (cnt != CNT_TOP)) begin
            cnt <= cnt + CNT_ONE;
        end
    end

endmodule

// File: rtl/ivt_status.sv
module ivt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // A set on the same edge as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/ivt_top.sv
module ivt_top
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    logic             run_q;
    logic [CNT_W-1:0] reload_q;
    logic             reload_wr;
    logic             status_clr;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             ovf_evt;
    logic             flag;

    ivt_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .flag       (flag),
        .rd_data    (rd_data),
        .run_q      (run_q),
        .reload_q   (reload_q),
        .reload_wr  (reload_wr),
        .status_clr (status_clr)
    );

    ivt_prescale #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .tick_en (tick_en),
        .tick    (tick)
    );

    ivt_ctr_fsm #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run_q),
        .tick         (tick),
        .reload_wr    (reload_wr),
        .reload_wdata (wr_data[CNT_W-1:0]),
        .reload_q     (reload_q),
        .cnt          (cnt),
        .ovf_evt      (ovf_evt)
    );

    ivt_status u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ovf_evt),
        .clr   (status_clr),
        .flag  (flag)
    );

    assign irq = flag;

endmodule

// File: rtl/ivt_chk.sv
module ivt_chk
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_bit0,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic              ovf_evt,
    input logic              run_q,
    input logic              reload_wr,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  cnt
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);

    logic clr_req, keep_req;
    assign clr_req  = wr_en && (wr_addr == A_STATUS) && wr_bit0;
    assign keep_req = wr_en && (wr_addr == A_STATUS) && !wr_bit0;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> irq);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !ovf_evt) |=> !irq);

    // R8
    w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && keep_req) |=> irq);

    // R5
    ovf_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |-> (cnt == '1) && run_q);

    // R4
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !reload_wr && !$past(ovf_evt)) |=> $stable(cnt));

    // R3
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> (cnt == reload_q));

    // R6
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt ##1 !reload_wr |=> (cnt == $past(reload_q)));

    // R10
    unused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > A_STATUS) |-> (rd_data == '0));

endmodule

bind ivt_top ivt_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) ivt_chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_bit0   (wr_data[0]),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .irq       (irq),
    .ovf_evt   (ovf_evt),
    .run_q     (run_q),
    .reload_wr (reload_wr),
    .reload_q  (reload_q),
    .cnt       (cnt)
);

// File: tb/ivt_top_tb_top.sv
module ivt_top_tb_top;

    localparam int WD_LIMIT = 100000;

    logic        clk     = 1'b0;
    logic        rst_n   = 1'b0;
    logic        tick_en = 1'b1;
    logic        wr_en   = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;

    int cyc     = 0;
    int n_chk   = 0;
    int n_bad   = 0;
    int last_wr = 0;
    bit gate    = 1'b0;

    ivt_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (gate) tick_en <= ~tick_en;
        else      tick_en <= 1'b1;
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc == WD_LIMIT) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected < %0d", cyc, WD_LIMIT);
            report();
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Write takes effect at the edge numbered last_wr
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        last_wr = cyc;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_irq(input int lim, output int at);
        int k;
        k = 0;
        while (!irq && k < lim) begin
            @(negedge clk);
            k++;
        end
        at = cyc;
    endtask

    task automatic aim(input int target);
        while (cyc < target - 2) @(negedge clk);
    endtask

    initial begin
        logic [15:0] d;
        int e, r1, r2, t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, read through every address
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check(d == 16'h0, "R1 reset read", d, 0);
        end
        check(irq == 1'b0, "R1 irq low after reset", irq, 0);

        // Sweep of reload values near the top of the range
        for (int i = 0; i < 16; i++) begin
            logic [15:0] rv;
            int per;
            rv  = 16'hFFFF - 16'(i);
            per = 16 * (65536 - int'(rv));
            wr(0, 16'h0);
            wr(2, 16'h1);
            wr(1, rv);
            rd(1, d);
            check(d == rv, "R3 reload readback", d, rv);
            wr(0, 16'h1);
            e = last_wr;
            rd(0, d);
            check(d == 16'h1, "R10 run bit readback", d, 1);
            wait_irq(per + 50, r1);
            check(r1 - e == per, "R2 R5 first overflow delay", r1 - e, per);
            rd(2, d);
            check(d == 16'h1, "R10 flag readback", d, 1);
            wr(2, 16'h1);
            check(irq == 1'b0, "R8 clear by writing 1", irq, 0);
            wait_irq(per + 50, r2);
            check(r2 - r1 == per, "R6 auto-reload period", r2 - r1, per);
        end

        // R8 writing 0 to status leaves the flag set
        wr(2, 16'h0);
        check(irq == 1'b1, "R8 write 0 ignored", irq, 1);
        rd(2, d);
        check(d == 16'h1, "R8 flag still reads 1", d, 1);

        // R10 unused address reads zero with registers non-zero
        rd(3, d);
        check(d == 16'h0, "R10 unused address", d, 0);

        // R9 clear lands on the overflow edge
        wr(0, 16'h0);
        wr(2, 16'h1);
        wr(1, 16'hFFFC);
        wr(0, 16'h1);
        wait_irq(200, r1);
        wr(2, 16'h1);
        check(irq == 1'b0, "R8 clear before collision", irq, 0);
        aim(r1 + 64);
        wr(2, 16'h1);
        check(irq == 1'b1, "R9 set wins over clear", irq, 1);

        // R4 stop freezes the counter, resume restarts the prescaler
        wr(0, 16'h0);
        wr(2, 16'h1);
        wr(1, 16'hFFF0);
        wr(0, 16'h1);
        e = last_wr;
        aim(e + 53);
        wr(0, 16'h0);
        repeat (400) @(negedge clk);
        check(irq == 1'b0, "R4 no overflow while stopped", irq, 0);
        wr(0, 16'h1);
        e = last_wr;
        wait_irq(400, r1);
        check(r1 - e == 208, "R4 resume from frozen count", r1 - e, 208);

        // R3 reload write while running loads the counter
        wr(0, 16'h0);
        wr(2, 16'h1);
        wr(1, 16'hFF00);
        wr(0, 16'h1);
        e = last_wr;
        aim(e + 39);
        wr(1, 16'hFFF8);
        wait_irq(400, r1);
        check(r1 - e == 160, "R3 live reload write", r1 - e, 160);

        // R7 tick enable on every second cycle doubles the period
        wr(0, 16'h0);
        wr(2, 16'h1);
        wr(1, 16'hFFF8);
        gate = 1'b1;
        wr(0, 16'h1);
        wait_irq(600, r1);
        wr(2, 16'h1);
        wait_irq(600, r2);
        t = r2 - r1;
        check(t == 256, "R7 gated tick period", t, 256);
        gate = 1'b0;

        report();
    end

endmodule